// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates eleven interrupt request flags on behalf of a small 8-bit processor core. Each source carries its own enable bit and a one-bit level (low or high), and a global enable gates every ordinary source. The winning request is presented to the core as a request strobe together with a 16-bit vector address. The core confirms the vector fetch with an acknowledge and closes a service routine with a one-cycle return pulse.

A two-bit in-service register records which levels are currently being serviced. A high-level request can therefore interrupt a low-level routine, while a request at the level already in service cannot. Within one level, a fixed polling order breaks ties. This order is not the same as the ascending order of the vector addresses.

The watchdog source is a special case. It is always treated as high level, it ignores both the global enable and its own enable bit, and it is gated by its own mode select and by a flag stating that the watchdog timeout is nonzero. The request flags are plain inputs. The peripherals clear them.

Top module: `intc_two_level`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `int_req` is 0, `int_vector` is 0x0000 and no level is in service.
- R2: An ordinary source (any index except 1) counts as pending only when its flag, its `src_en` bit and `glob_en` are all 1.
- R3: The watchdog source is index 1. It counts as pending when its flag, `wdt_irq_mode` and `wdt_tmo_nz` are all 1, whatever `glob_en`, `src_en[1]` and `src_hi[1]` are. It is always treated as high level.
- R4: A `src_hi` bit of 1 marks a high-level source. When pending sources of both levels are eligible, a high-level source wins.
- R5: Within one level, the lowest index wins. The indices, from first to last, are: 0 supply monitor, 1 watchdog, 2 external 0, 3 ADC, 4 timer 0, 5 external 1, 6 timer 1, 7 SPI/I2C, 8 serial, 9 timer 2, 10 interval counter.
- R6: The vectors are: external 0 0x0003, timer 0 0x000B, external 1 0x0013, timer 1 0x001B, serial 0x0023, timer 2 0x002B, ADC 0x0033, SPI/I2C 0x003B, supply monitor 0x0043, interval counter 0x0053, watchdog 0x005B.
- R7: `int_req` rises one clock after an eligible source becomes pending. It then stays high with an unchanged `int_vector` until `core_ack`. In the clock after the acknowledge, `int_req` is 0 and `int_vector` is 0x0000.
- R8: An acknowledged request marks the winner's level as in service.
- R9: With the high level in service, no request is raised. With only the low level in service, only high-level sources are eligible.
- R10: A `core_reti` pulse clears the high in-service bit if it is set, and otherwise clears the low bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_flags | input | 11 | Raw request flags, indexed by polling order |
| src_en | input | 11 | Per-source enable |
| src_hi | input | 11 | Per-source level, 1 = high |
| glob_en | input | 1 | Global enable for ordinary sources |
| wdt_irq_mode | input | 1 | Watchdog set to interrupt mode |
| wdt_tmo_nz | input | 1 | Watchdog timeout is nonzero |
| core_ack | input | 1 | Core has taken the vector |
| core_reti | input | 1 | Return-from-interrupt pulse |
| int_req | output | 1 | Interrupt request to the core |
| int_vector | output | 16 | Vector address of the pending request |

## Verification
The bench builds the block with its default parameters: eleven sources, a 16-bit vector and the watchdog at index 1. This puts every entry of the vector map and the full polling order within reach of directed stimulus. The bench then nests a high-level routine inside a low-level one and unwinds both with two return pulses. It also drives the watchdog with the global enable off and with each of its two qualifiers cleared.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned SRC_COUNT = 11;
   localparam int unsigned LVL_LO    = 0;
   localparam int unsigned LVL_HI    = 1;

   // Position of each source in the vector space; vector = 8 * slot + 3.
   function automatic logic [15:0] vector_of(input int unsigned idx);
      int unsigned slot;
      case (idx)
         0:       slot = 8;   // supply monitor
         1:       slot = 11;  // watchdog
         2:       slot = 0;   // external 0
         3:       slot = 6;   // ADC
         4:       slot = 1;   // timer 0
         5:       slot = 2;   // external 1
         6:       slot = 3;   // timer 1
         7:       slot = 7;   // SPI/I2C
         8:       slot = 4;   // serial
         9:       slot = 5;   // timer 2
         default: slot = 10;  // interval counter
      endcase
      return 16'(slot * 8 + 3);
   endfunction

endpackage

// File: rtl/intc_qualify.sv
module intc_qualify #(
   parameter int unsigned N_SRC   = 11,
   parameter int unsigned WDT_IDX = 1
) (
   input  logic [N_SRC-1:0] flags,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] hi,
   input  logic             glob_en,
   input  logic             wdt_mode,
   input  logic             wdt_nz,
   output logic [N_SRC-1:0] cand_hi,
   output logic [N_SRC-1:0] cand_lo
);

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      if (g == WDT_IDX) begin : g_wdt
         assign cand_hi[g] = flags[g] & wdt_mode & wdt_nz;
         assign cand_lo[g] = 1'b0;
      end else begin : g_std
         logic live;
         assign live       = flags[g] & en[g] & glob_en;
         assign cand_hi[g] = live & hi[g];
         assign cand_lo[g] = live & ~hi[g];
      end
   end

endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
   parameter int unsigned N = 11
) (
   input  logic [N-1:0]         req,
   output logic                 valid,
   output logic [$clog2(N)-1:0] idx
);

   localparam int unsigned IW = $clog2(N);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign valid = |req;

endmodule

// File: rtl/intc_two_level.sv
module intc_two_level #(
   parameter int unsigned N_SRC   = intc_pkg::SRC_COUNT,
   parameter int unsigned VEC_W   = 16,
   parameter int unsigned WDT_IDX = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_SRC-1:0]  irq_flags,
   input  logic [N_SRC-1:0]  src_en,
   input  logic [N_SRC-1:0]  src_hi,
   input  logic              glob_en,
   input  logic              wdt_irq_mode,
   input  logic              wdt_tmo_nz,
   input  logic              core_ack,
   input  logic              core_reti,
   output logic              int_req,
   output logic [VEC_W-1:0]  int_vector
);

   localparam int unsigned IW = $clog2(N_SRC);

   if (N_SRC != intc_pkg::SRC_COUNT) begin : g_bad_count
      $error("intc_two_level: the vector map covers exactly 11 sources");
   end
   if (VEC_W < 7 || VEC_W > 16) begin : g_bad_width
      $error("intc_two_level: VEC_W must lie in 7..16");
   end
   if (WDT_IDX >= N_SRC) begin : g_bad_wdt
      $error("intc_two_level: WDT_IDX out of range");
   end

   logic [N_SRC-1:0] cand_hi, cand_lo;
   logic             hi_valid, lo_valid;
   logic [IW-1:0]    hi_idx, lo_idx;

   logic             req_q;
   logic [VEC_W-1:0] vec_q;
   logic             lvl_q;
   logic [1:0]       isr_q, isr_n;

   logic             win_valid;
   logic             win_lvl;
   logic [IW-1:0]    win_idx;
   logic [VEC_W-1:0] win_vec;

   intc_qualify #(.N_SRC(N_SRC), .WDT_IDX(WDT_IDX)) u_qual (
      .flags   (irq_flags),
      .en      (src_en),
      .hi      (src_hi),
      .glob_en (glob_en),
      .wdt_mode(wdt_irq_mode),
      .wdt_nz  (wdt_tmo_nz),
      .cand_hi (cand_hi),
      .cand_lo (cand_lo)
   );

   intc_pick #(.N(N_SRC)) u_pick_hi (
      .req  (cand_hi),
      .valid(hi_valid),
      .idx  (hi_idx)
   );

   intc_pick #(.N(N_SRC)) u_pick_lo (
      .req  (cand_lo),
      .valid(lo_valid),
      .idx  (lo_idx)
   );

   // A level in service masks its own level and everything below it.
   always_comb begin
      win_valid = 1'b0;
      win_lvl   = 1'b0;
      win_idx   = lo_idx;
      if (hi_valid && !isr_q[intc_pkg::LVL_HI]) begin
         win_valid = 1'b1;
         win_lvl   = 1'b1;
         win_idx   = hi_idx;
      end else if (lo_valid && isr_q == 2'b00) begin
         win_valid = 1'b1;
      end
      win_vec = VEC_W'(intc_pkg::vector_of(int'(win_idx)));
   end

   always_comb begin
      isr_n = isr_q;
      if (core_reti) begin
         if (isr_q[intc_pkg::LVL_HI]) isr_n[intc_pkg::LVL_HI] = 1'b0;
         else                         isr_n[intc_pkg::LVL_LO] = 1'b0;
      end
      if (req_q && core_ack) isr_n[lvl_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q <= 1'b0;
         vec_q <= '0;
         lvl_q <= 1'b0;
         isr_q <= 2'b00;
      end else begin
         isr_q <= isr_n;
         if (req_q) begin
            if (core_ack) begin
               req_q <= 1'b0;
               vec_q <= '0;
            end
         end else if (win_valid) begin
            req_q <= 1'b1;
            vec_q <= win_vec;
            lvl_q <= win_lvl;
         end
      end
   end

   assign int_req    = req_q;
   assign int_vector = vec_q;

endmodule

// File: rtl/intc_two_level_chk.sv
module intc_two_level_chk #(
   parameter int unsigned VEC_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             core_ack,
   input logic             core_reti,
   input logic             int_req,
   input logic [VEC_W-1:0] int_vector,
   input logic [1:0]       isr
);

   AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (rst)
      !int_req |-> int_vector == '0);  // R7

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
      int_req && !core_ack |=> int_req && $stable(int_vector));  // R7

   AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
      int_req && core_ack |=> !int_req);  // R7

   AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
      int_req && core_ack |=> isr != 2'b00);  // R8

   AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
      !int_req && isr[1] |=> !int_req);  // R9

   AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
      core_reti && isr[1] && !(int_req && core_ack) |=> !isr[1] && isr[0] == $past(isr[0]));  // R10

   AST_RETI_LO_NEXT: assert property (@(posedge clk) disable iff (rst)
      core_reti && isr == 2'b01 && !(int_req && core_ack) |=> isr == 2'b00);  // R10

endmodule

bind intc_two_level intc_two_level_chk #(.VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .core_ack  (core_ack),
   .core_reti (core_reti),
   .int_req   (int_req),
   .int_vector(int_vector),
   .isr       (isr_q)
);

// File: tb/test_intc_two_level.sv
module test_intc_two_level;

   localparam int unsigned N = 11;

   logic          clk = 1'b0;
   logic          rst;
   logic [N-1:0]  irq_flags, src_en, src_hi;
   logic          glob_en, wdt_irq_mode, wdt_tmo_nz, core_ack, core_reti;
   logic          int_req;
   logic [15:0]   int_vector;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;  // 125 MHz

   intc_two_level i_intc_two_level (
      .clk(clk), .rst(rst), .irq_flags(irq_flags), .src_en(src_en),
      .src_hi(src_hi), .glob_en(glob_en), .wdt_irq_mode(wdt_irq_mode),
      .wdt_tmo_nz(wdt_tmo_nz), .core_ack(core_ack), .core_reti(core_reti),
      .int_req(int_req), .int_vector(int_vector)
   );

   function automatic logic [15:0] exp_vec(input int idx);
      case (idx)
         0: return 16'h0043;
         1: return 16'h005B;
         2: return 16'h0003;
         3: return 16'h0033;
         4: return 16'h000B;
         5: return 16'h0013;
         6: return 16'h001B;
         7: return 16'h003B;
         8: return 16'h0023;
         9: return 16'h002B;
         default: return 16'h0053;
      endcase
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic expect_out(input string req, input logic er, input logic [15:0] ev);
      checks++;
      if (int_req !== er || int_vector !== ev) begin
         errors++;
         $display("FAIL %s: req=%0b vec=%h, expected req=%0b vec=%h", req, int_req, int_vector, er, ev);
      end
   endtask

   task automatic do_ack(input string req);
      @(negedge clk); core_ack = 1'b1; irq_flags = '0;
      tick();
      expect_out(req, 1'b0, 16'h0000);
      @(negedge clk); core_ack = 1'b0;
   endtask

   task automatic do_reti();
      @(negedge clk); core_reti = 1'b1;
      tick();
      @(negedge clk); core_reti = 1'b0;
   endtask

   task automatic defaults();
      irq_flags = '0; src_en = '1; src_hi = '0; glob_en = 1'b1;
      wdt_irq_mode = 1'b1; wdt_tmo_nz = 1'b1; core_ack = 1'b0; core_reti = 1'b0;
   endtask

   task automatic t_reset();
      defaults();
      rst = 1'b1;
      tick(); tick();
      expect_out("R1 in reset", 1'b0, 16'h0000);
      @(negedge clk); rst = 1'b0;
      tick();
      expect_out("R1 after reset", 1'b0, 16'h0000);
   endtask

   task automatic t_vectors();
      for (int i = 0; i < N; i++) begin
         @(negedge clk); irq_flags = N'(1) << i;
         tick();
         expect_out($sformatf("R6 vector of source %0d", i), 1'b1, exp_vec(i));
         do_ack("R7 drop after ack");
         do_reti();
      end
   endtask

   task automatic t_gating();
      @(negedge clk); glob_en = 1'b0; irq_flags = N'(1) << 2;
      tick(); tick();
      expect_out("R2 global enable off", 1'b0, 16'h0000);
      @(negedge clk); glob_en = 1'b1; src_en[2] = 1'b0;
      tick(); tick();
      expect_out("R2 source enable off", 1'b0, 16'h0000);
      @(negedge clk); src_en = '1; glob_en = 1'b0; src_en[1] = 1'b0; src_hi[1] = 1'b0;
      irq_flags = N'(1) << 1;
      tick();
      expect_out("R3 watchdog ignores enables", 1'b1, 16'h005B);
      do_ack("R3 watchdog ack");
      // watchdog was taken as high level: a high source must now be blocked
      @(negedge clk); glob_en = 1'b1; src_en = '1; src_hi = N'(1) << 9; irq_flags = N'(1) << 9;
      tick(); tick();
      expect_out("R3 watchdog serviced as high level", 1'b0, 16'h0000);
      do_reti();
      tick();
      expect_out("R3 high level freed by return", 1'b1, 16'h002B);
      do_ack("R3 ack");
      do_reti();
      @(negedge clk); src_hi = '0; wdt_irq_mode = 1'b0; irq_flags = N'(1) << 1;
      tick(); tick();
      expect_out("R3 watchdog mode off", 1'b0, 16'h0000);
      @(negedge clk); wdt_irq_mode = 1'b1; wdt_tmo_nz = 1'b0;
      tick(); tick();
      expect_out("R3 watchdog timeout zero", 1'b0, 16'h0000);
      @(negedge clk); defaults();
   endtask

   task automatic t_order();
      @(negedge clk); src_hi = N'(1) << 9; irq_flags = (N'(1) << 0) | (N'(1) << 9);
      tick();
      expect_out("R4 high level wins", 1'b1, 16'h002B);
      do_ack("R4 ack"); do_reti();
      @(negedge clk); src_hi = '0; irq_flags = (N'(1) << 0) | (N'(1) << 9);
      tick();
      expect_out("R5 index 0 before index 9", 1'b1, 16'h0043);
      do_ack("R5 ack"); do_reti();
      @(negedge clk); irq_flags = (N'(1) << 5) | (N'(1) << 4) | (N'(1) << 8);
      tick();
      expect_out("R5 timer 0 before external 1 and serial", 1'b1, 16'h000B);
      do_ack("R5 ack"); do_reti();
      @(negedge clk); src_hi = (N'(1) << 10) | (N'(1) << 6); irq_flags = (N'(1) << 10) | (N'(1) << 6) | (N'(1) << 2);
      tick();
      expect_out("R5 order inside high level", 1'b1, 16'h001B);
      do_ack("R5 ack"); do_reti();
      @(negedge clk); defaults();
   endtask

   task automatic t_hold();
      @(negedge clk); irq_flags = N'(1) << 5;
      tick();
      expect_out("R7 request raised", 1'b1, 16'h0013);
      @(negedge clk); irq_flags = N'(1) << 0;
      tick(); tick(); tick();
      expect_out("R7 held until ack", 1'b1, 16'h0013);
      do_ack("R7 ack"); do_reti();
   endtask

   task automatic t_nesting();
      @(negedge clk); src_hi = N'(1) << 9; irq_flags = N'(1) << 2;
      tick();
      expect_out("R8 low request", 1'b1, 16'h0003);
      do_ack("R8 ack low");
      @(negedge clk); irq_flags = N'(1) << 4;
      tick(); tick();
      expect_out("R9 low blocked in low service", 1'b0, 16'h0000);
      @(negedge clk); irq_flags = (N'(1) << 4) | (N'(1) << 9);
      tick();
      expect_out("R9 high preempts low", 1'b1, 16'h002B);
      do_ack("R8 ack high");
      @(negedge clk); irq_flags = (N'(1) << 4) | (N'(1) << 9);
      tick(); tick();
      expect_out("R9 all blocked in high service", 1'b0, 16'h0000);
      do_reti();
      tick();
      expect_out("R10 high cleared first", 1'b1, 16'h002B);
      do_ack("R10 ack");
      do_reti();
      @(negedge clk); irq_flags = N'(1) << 4;
      tick(); tick();
      expect_out("R10 low still in service", 1'b0, 16'h0000);
      do_reti();
      tick();
      expect_out("R10 low cleared by second return", 1'b1, 16'h000B);
      do_ack("R10 ack"); do_reti();
      @(negedge clk); defaults();
   endtask

   initial begin
      t_reset();
      t_vectors();
      t_gating();
      t_order();
      t_hold();
      t_nesting();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: run hung, got no end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule